// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static RAM Emulator

This block is a synthesizable stand-in for an asynchronous static RAM. It samples the memory's control pins, address bus and incoming data on a fast internal clock. It then behaves the way the asynchronous part would, seen at that clock's resolution. The array holds `2**ADDR_W` words of two `LANE_W`-bit lanes. A pin can switch the device into a narrow mode, where it is addressed one lane at a time. In that mode the topmost data pin stops carrying data and becomes the least-significant address bit.

Two chip selects of opposite polarity gate the device. A pair of lane selects picks the upper and lower halves of a word. Write enable and output enable choose between read, write and output-disable. The bidirectional data bus is split into three parts: an input bus, an output bus, and one output-enable bit per lane. The pad ring combines them into tri-state pins. The device captures a write only when the write overlap ends. The data stored is the data that was present on the last sampled cycle of the overlap.

Top module: `sram_emu`

## Requirements
- R1: If `cs1_n` is high or `cs2` is low, the device is deselected. Both `dq_oe` bits are 0 and no write takes place, whatever `we_n` and `oe_n` are.
- R2: In word mode (`byte_n` high) with `ub_n` and `lb_n` both high, the device is in standby. `dq_oe` is 0 and a low `we_n` writes nothing.
- R3: A word-mode read (selected, `we_n` high, `oe_n` low) drives lane 0 (`dq_out[7:0]`) when `lb_n` is low and lane 1 (`dq_out[15:8]`) when `ub_n` is low, with the stored bytes. A lane that is not driven reads 0 on `dq_out`.
- R4: When selected with `we_n` high and `oe_n` high, the device is in output disable and `dq_oe` is 0.
- R5: While `we_n` is low and the device is selected, `dq_oe` is 0 even when `oe_n` is low.
- R6: A word-mode write commits on the first sampled cycle after the overlap (selected and `we_n` low) ends, whichever signal ends it. It stores the data and address of the last sampled cycle of the overlap. Only lanes whose select was low in that cycle are updated.
- R7: In byte mode (`byte_n` low), `dq_in[15]` is the low address bit: 0 selects lane 0 of the word at `addr`, 1 selects lane 1. A write stores `dq_in[7:0]` into that lane only. `ub_n` and `lb_n` have no effect.
- R8: A byte-mode read drives only lane 0 (`dq_oe` = 01), carrying the lane picked by `dq_in[15]`. `ub_n` and `lb_n` have no effect.
- R9: `dq_oe` and `dq_out` follow the pin values sampled at the most recent rising clock edge. A committed write is visible to a read sampled at the same edge as the commit.
- R10: While `rst_n` is low, and after reset until pins are sampled, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset of the sampling registers |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane select, active low (word mode) |
| lb_n | input | 1 | Lower lane select, active low (word mode) |
| byte_n | input | 1 | Low selects byte mode |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Data from pins; top bit is the low address bit in byte mode |
| dq_out | output | 2*LANE_W | Data toward pins |
| dq_oe | output | 2 | Output enable per lane |

## Verification
The hardest case to reach from the ports is a write that ends through something other than chip select. Examples are `we_n` rising into output disable, or both lane selects rising while `we_n` is still low. In the second case the device drops to standby and the commit must still land. The stimulus holds such writes over several cycles and changes the data between them, so only the final sample may be stored. The bench then reads the words back in both word and byte mode, and uses half-word patterns to show that the untouched lane survives.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_HIZ   = 2'd3
   } op_e;
endpackage

// File: rtl/sram_emu_sample.sv
module sram_emu_sample #(
   parameter int            W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
   import sram_emu_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int DQ_W  = 2 * LANE_W
) (
   input  logic            cs1_n,
   input  logic            cs2,
   input  logic            we_n,
   input  logic            oe_n,
   input  logic            ub_n,
   input  logic            lb_n,
   input  logic            byte_n,
   input  logic [DQ_W-1:0] dq_in,
   output op_e             op,
   output logic [1:0]      lane_mask,
   output logic [DQ_W-1:0] wdata
);
   logic narrow;
   logic half;
   logic sel;

   always_comb begin
      narrow = !byte_n;
      half   = dq_in[DQ_W-1];
      sel    = !cs1_n && cs2 && (narrow || !(ub_n && lb_n));
      if (narrow) lane_mask = half ? 2'b10 : 2'b01;
      else        lane_mask = {!ub_n, !lb_n};
      if (!sel)       op = OP_IDLE;
      else if (!we_n) op = OP_WRITE;
      else if (!oe_n) op = OP_READ;
      else            op = OP_HIZ;
      wdata = narrow ? {2{dq_in[LANE_W-1:0]}} : dq_in;
   end
endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 8,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int DQ_W  = 2 * LANE_W
) (
   input  logic              clk,
   input  logic [1:0]        we_mask,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DQ_W-1:0]   wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DQ_W-1:0]   rdata
);
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we_mask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/sram_emu.sv
module sram_emu
   import sram_emu_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 8,
   localparam int DQ_W  = 2 * LANE_W,
   localparam int BUS_W = 7 + ADDR_W + DQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic [1:0]        dq_oe
);
   localparam logic [BUS_W-1:0] IDLE_PINS = {7'b1011111, {(ADDR_W + DQ_W){1'b0}}};

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("sram_emu: ADDR_W out of range");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("sram_emu: LANE_W must be positive");
   end

   logic [BUS_W-1:0] pin_bus, s_bus, p_bus;
   assign pin_bus = {cs1_n, cs2, we_n, oe_n, ub_n, lb_n, byte_n, addr, dq_in};

   sram_emu_sample #(.W(BUS_W), .RST_VAL(IDLE_PINS)) u_now (
      .clk(clk), .rst_n(rst_n), .d(pin_bus), .q(s_bus));
   sram_emu_sample #(.W(BUS_W), .RST_VAL(IDLE_PINS)) u_prev (
      .clk(clk), .rst_n(rst_n), .d(s_bus), .q(p_bus));

   logic s_cs1_n, s_cs2, s_we_n, s_oe_n, s_ub_n, s_lb_n, s_byte_n;
   logic p_cs1_n, p_cs2, p_we_n, p_oe_n, p_ub_n, p_lb_n, p_byte_n;
   logic [ADDR_W-1:0] s_addr, p_addr;
   logic [DQ_W-1:0]   s_dq, p_dq;
   assign {s_cs1_n, s_cs2, s_we_n, s_oe_n, s_ub_n, s_lb_n, s_byte_n, s_addr, s_dq} = s_bus;
   assign {p_cs1_n, p_cs2, p_we_n, p_oe_n, p_ub_n, p_lb_n, p_byte_n, p_addr, p_dq} = p_bus;

   op_e              s_op, p_op;
   logic [1:0]       s_mask, p_mask;
   logic [DQ_W-1:0]  s_wdata, p_wdata;

   sram_emu_decode #(.LANE_W(LANE_W)) u_dec_now (
      .cs1_n(s_cs1_n), .cs2(s_cs2), .we_n(s_we_n), .oe_n(s_oe_n),
      .ub_n(s_ub_n), .lb_n(s_lb_n), .byte_n(s_byte_n), .dq_in(s_dq),
      .op(s_op), .lane_mask(s_mask), .wdata(s_wdata));
   sram_emu_decode #(.LANE_W(LANE_W)) u_dec_prev (
      .cs1_n(p_cs1_n), .cs2(p_cs2), .we_n(p_we_n), .oe_n(p_oe_n),
      .ub_n(p_ub_n), .lb_n(p_lb_n), .byte_n(p_byte_n), .dq_in(p_dq),
      .op(p_op), .lane_mask(p_mask), .wdata(p_wdata));

   // a write lands on the first sample after the overlap closes
   logic       commit;
   logic [1:0] we_mask;
   assign commit  = (p_op == OP_WRITE) && (s_op != OP_WRITE);
   assign we_mask = commit ? p_mask : 2'b00;

   logic [DQ_W-1:0] rdata;
   sram_emu_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
      .clk(clk), .we_mask(we_mask), .waddr(p_addr), .wdata(p_wdata),
      .raddr(s_addr), .rdata(rdata));

   logic s_narrow, s_half;
   assign s_narrow = !s_byte_n;
   assign s_half   = s_dq[DQ_W-1];

   logic [1:0] rd_oe;
   always_comb begin
      rd_oe = 2'b00;
      if (s_op == OP_READ) rd_oe = s_narrow ? 2'b01 : s_mask;
   end
   assign dq_oe = rd_oe;

   logic [LANE_W-1:0] lane_val [2];
   assign lane_val[0] = (s_narrow && s_half) ? rdata[LANE_W +: LANE_W] : rdata[0 +: LANE_W];
   assign lane_val[1] = rdata[LANE_W +: LANE_W];

   for (genvar g = 0; g < 2; g++) begin : g_out
      assign dq_out[g*LANE_W +: LANE_W] = rd_oe[g] ? lane_val[g] : '0;
   end
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs1_n,
   input logic       cs2,
   input logic       we_n,
   input logic       oe_n,
   input logic       ub_n,
   input logic       lb_n,
   input logic       byte_n,
   input logic [1:0] dq_oe
);
   AST_DESELECT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(cs1_n) || !$past(cs2))) |-> dq_oe == 2'b00); // R1
   AST_WORD_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(byte_n) && $past(ub_n) && $past(lb_n)) |-> dq_oe == 2'b00); // R2
   AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cs1_n) && $past(cs2) && $past(we_n) && !$past(oe_n)
       && $past(byte_n)) |-> dq_oe == {!$past(ub_n), !$past(lb_n)}); // R3
   AST_OUTDIS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we_n) && $past(oe_n)) |-> dq_oe == 2'b00); // R4
   AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(we_n)) |-> dq_oe == 2'b00); // R5
   AST_BYTE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(byte_n) && !$past(cs1_n) && $past(cs2) && $past(we_n)
       && !$past(oe_n)) |-> dq_oe == 2'b01); // R8
endmodule

bind sram_emu sram_emu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n),
   .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .byte_n(byte_n), .dq_oe(dq_oe));

// File: tb/sram_emu_tb.sv
module sram_emu_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
   logic ub_n = 1'b1, lb_n = 1'b1, byte_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_emu #(.ADDR_W(ADDR_W), .LANE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n),
      .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .byte_n(byte_n), .addr(addr),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

   typedef struct {
      int          due;
      logic [1:0]  oe;
      logic [15:0] out;
      string       tag;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare outputs at the falling edge in the cycle each item is due
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (dq_oe !== it.oe || dq_out !== it.out) begin
            errors++;
            $display("FAIL %s: oe=%b out=%h expected oe=%b out=%h",
                     it.tag, dq_oe, dq_out, it.oe, it.out);
         end
      end
   end

   task automatic apply(input logic c1n, input logic c2, input logic wen, input logic oen,
                        input logic ubn, input logic lbn, input logic bytn,
                        input logic [ADDR_W-1:0] a, input logic [15:0] d,
                        input logic [1:0] eoe, input logic [15:0] eout, input string tag);
      item_t it;
      @(negedge clk);
      cs1_n = c1n; cs2 = c2; we_n = wen; oe_n = oen;
      ub_n = ubn; lb_n = lbn; byte_n = bytn; addr = a; dq_in = d;
      it.due = cyc + 1; it.oe = eoe; it.out = eout; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic desel();
      apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, 2'b00, 16'h0, "R1 deselected");
   endtask

   // oe_n held low during the write: outputs must still float (R5)
   task automatic w_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                         input logic ubn, input logic lbn);
      apply(1'b0, 1'b1, 1'b0, 1'b0, ubn, lbn, 1'b1, a, d, 2'b00, 16'h0, "R5 write floats");
   endtask

   task automatic r_word(input logic [ADDR_W-1:0] a, input logic ubn, input logic lbn,
                         input logic [15:0] exp, input string tag);
      logic [15:0] m;
      m = {{8{!ubn}}, {8{!lbn}}};
      apply(1'b0, 1'b1, 1'b1, 1'b0, ubn, lbn, 1'b1, a, 16'h0, {!ubn, !lbn}, exp & m, tag);
   endtask

   task automatic w_byte(input logic [ADDR_W-1:0] a, input logic half, input logic [7:0] d,
                         input logic ubn, input logic lbn);
      apply(1'b0, 1'b1, 1'b0, 1'b1, ubn, lbn, 1'b0, a, {half, 7'h00, d},
            2'b00, 16'h0, "R7 byte write floats");
   endtask

   task automatic r_byte(input logic [ADDR_W-1:0] a, input logic half, input logic ubn,
                         input logic lbn, input logic [7:0] exp, input string tag);
      apply(1'b0, 1'b1, 1'b1, 1'b0, ubn, lbn, 1'b0, a, {half, 15'h0}, 2'b01, {8'h00, exp}, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (dq_oe !== 2'b00) begin
         errors++;
         $display("FAIL R10: oe=%b expected oe=00 in reset", dq_oe);
      end
      rst_n = 1'b1;

      // R6 / R9: full-word write, commit visible to the next read
      w_word(10'd5, 16'h1234, 1'b0, 1'b0);
      desel();
      r_word(10'd5, 1'b0, 1'b0, 16'h1234, "R9 R6 word readback");

      // R6: upper lane only
      w_word(10'd5, 16'hAB00, 1'b0, 1'b1);
      desel();
      r_word(10'd5, 1'b1, 1'b0, 16'h1234, "R3 lower lane only");
      r_word(10'd5, 1'b0, 1'b1, 16'hAB00, "R3 upper lane only");
      r_word(10'd5, 1'b0, 1'b0, 16'hAB34, "R6 lane-masked write");

      // R2: no lane selected in word mode
      apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 16'hFFFF, 2'b00, 16'h0, "R2 standby");
      desel();
      r_word(10'd5, 1'b0, 1'b0, 16'hAB34, "R2 no write in standby");

      // R1: each chip select alone blocks the write
      apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000, 2'b00, 16'h0, "R1 cs1 high");
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000, 2'b00, 16'h0, "R1 cs2 low");
      desel();
      r_word(10'd5, 1'b0, 1'b0, 16'hAB34, "R1 no write when deselected");

      // R4: output disable
      apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0, 2'b00, 16'h0, "R4 output disable");

      // R6: long write, data changes, ended by we_n rising into output disable
      apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd9, 16'h0A0A, 2'b00, 16'h0, "R5 write cycle 1");
      apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd9, 16'hB0B0, 2'b00, 16'h0, "R5 write cycle 2");
      apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd9, 16'h5555, 2'b00, 16'h0, "R4 end by we_n");
      r_word(10'd9, 1'b0, 1'b0, 16'hB0B0, "R6 last sampled data kept");

      // R6: write ended by both lane selects rising
      w_word(10'd10, 16'h1357, 1'b0, 1'b0);
      apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd10, 16'hFFFF, 2'b00, 16'h0, "R2 end by lanes");
      r_word(10'd10, 1'b0, 1'b0, 16'h1357, "R6 commit on lane release");

      // R7 / R8: byte mode
      w_word(10'd7, 16'h1111, 1'b0, 1'b0);
      desel();
      w_byte(10'd7, 1'b1, 8'h5A, 1'b1, 1'b1);
      desel();
      r_word(10'd7, 1'b0, 1'b0, 16'h5A11, "R7 upper half only");
      r_byte(10'd7, 1'b0, 1'b1, 1'b1, 8'h11, "R8 byte read low half");
      r_byte(10'd7, 1'b1, 1'b0, 1'b0, 8'h5A, "R8 byte read high half, selects ignored");
      w_byte(10'd7, 1'b0, 8'hC3, 1'b0, 1'b0);
      desel();
      r_word(10'd7, 1'b0, 1'b0, 16'h5AC3, "R7 lower half, selects ignored");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule